// File: doc/BRIEF.md
# Flash boot image selector

This block decides which configuration image the FPGA loads from its flash and keeps the factory image safe. The flash holds up to four images, each starting on an 8 MiB boundary (slot number times 0x800000). After reset, two board switches, passed through a two-flop synchronizer, choose the power-up slot. The block then issues one configuration-start pulse together with the byte address of that slot.

A host command path lets software pick another slot and commit it. A commit produces a fresh configuration-start pulse. Host requests to erase a slot or program a word first pass a screen. Anything that would change slot 0 is refused and raises a sticky protection flag. A safe-erase command clears slots 1 and up, one after another, and never touches slot 0. Flash work goes out as a request held with its operation and address until the flash side grants it.

Top module: `boot_image_selector`

## Requirements
- R1: Both status flags read 0 during reset. Busy reads 1, and neither the configuration-start pulse nor a flash request is active. The switch value is read as a binary slot number with sw_i[0] as the least significant bit. It passes through two flops and is latched at the third rising edge after reset release. One configuration-start pulse follows, carrying address slot × 0x800000, and active_slot_o reports that slot.
- R2: Host opcodes are SELECT=0, COMMIT=1, ERASE=2, PROGRAM=3, SAFE_ERASE=4, CLEAR=5. SELECT stores cmd_slot_i. COMMIT of a stored slot below 4 gives a configuration-start pulse one cycle high in the cycle after the command. The pulse carries address slot × 0x800000, and active_slot_o is updated to that slot.
- R3: SELECT of a slot number of 4 or more sets slot_err_o. COMMIT while such a slot is stored sets slot_err_o and gives no pulse, and active_slot_o keeps its value. ERASE of a slot of 4 or more sets slot_err_o and gives no flash request.
- R4: ERASE of slot 1 to 3 raises flash_req_o with flash_op_o=0 (erase) and flash_addr_o = slot × 0x800000. Request, operation and address stay fixed until a cycle in which flash_gnt_i is high.
- R5: An ERASE of slot 0, or a PROGRAM whose address lies below 0x800000, raises no flash request and sets prot_err_o. No flash request ever carries an address below 0x800000.
- R6: PROGRAM at an address of 0x800000 or above raises flash_req_o with flash_op_o=1 (program) and that address.
- R7: SAFE_ERASE issues erase requests at 0x800000, 0x1000000 and 0x1800000 in that order. Each request is held until granted, and the next follows in the cycle after the grant.
- R8: Both flags are sticky. CLEAR with cmd_addr_i[0]=1 clears prot_err_o, and CLEAR with cmd_addr_i[1]=1 clears slot_err_o. A flag whose bit is 0 is left as it is.
- R9: A command presented while busy_o is high is ignored. busy_o is high before boot completes, while a flash request is pending, and in the cycle of a configuration-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_i | input | 2 | Asynchronous boot switches, binary slot number |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_op_i | input | 3 | Host opcode |
| cmd_slot_i | input | 3 | Slot number for SELECT and ERASE |
| cmd_addr_i | input | 25 | Byte address for PROGRAM, clear mask for CLEAR |
| busy_o | output | 1 | Commands are ignored while high |
| active_slot_o | output | 2 | Slot of the last configuration start |
| prot_err_o | output | 1 | Sticky: a request that touched slot 0 was refused |
| slot_err_o | output | 1 | Sticky: a slot number out of range was used |
| cfg_start_o | output | 1 | One-cycle configuration-start pulse |
| cfg_addr_o | output | 25 | Flash byte address to configure from |
| flash_req_o | output | 1 | Flash operation request |
| flash_op_o | output | 1 | 0 erase slot, 1 program |
| flash_addr_o | output | 25 | Flash byte address of the request |
| flash_gnt_i | input | 1 | Flash accepts the request in this cycle |

## Verification
A command sampled at a rising edge shows its result in the very next cycle. The pulse, the flags and the raised flash request all appear there, and the bench samples them at the falling edge straight after. The boot pulse is due one cycle after the third rising edge following reset release. A flash model grants each request three cycles after it appears. The scoreboard pops an expected operation and address at each granted cycle and an expected address at each pulse. A pulse with nothing queued, or a refused request that still reaches the flash, is therefore reported in the cycle it occurs.

// File: rtl/bis_pkg.sv
package bis_pkg;
    typedef enum logic [2:0] {
        OP_SELECT     = 3'd0,
        OP_COMMIT     = 3'd1,
        OP_ERASE      = 3'd2,
        OP_PROGRAM    = 3'd3,
        OP_SAFE_ERASE = 3'd4,
        OP_CLEAR      = 3'd5
    } host_op_e;

    typedef enum logic [1:0] {
        JOB_ERASE   = 2'd0,
        JOB_PROGRAM = 2'd1,
        JOB_SAFE    = 2'd2
    } job_e;

    localparam logic FL_ERASE   = 1'b0;
    localparam logic FL_PROGRAM = 1'b1;
endpackage

// File: rtl/bis_sync.sv
module bis_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.s2;
endmodule

// File: rtl/bis_flash_seq.sv
module bis_flash_seq
    import bis_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int SLOT_SHIFT = 23,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int ADDR_W    = SLOT_SHIFT + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_valid_i,
    input  job_e              job_kind_i,
    input  logic [ADDR_W-1:0] job_addr_i,
    output logic              seq_busy_o,
    output logic              flash_req_o,
    output logic              flash_op_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    input  logic              flash_gnt_i
);
    localparam logic [IDX_W:0] SLOT_END = (IDX_W+1)'(NUM_SLOTS);

    typedef struct packed {
        logic              req;
        logic              op;
        logic [ADDR_W-1:0] addr;
        logic              safe;
        logic [IDX_W:0]    nxt;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [ADDR_W-1:0] slot_base(input logic [IDX_W-1:0] s);
        return {s, {SLOT_SHIFT{1'b0}}};
    endfunction

    always_comb begin
        seq_d = seq_q;
        if (seq_q.req) begin
            if (flash_gnt_i) begin
                if (seq_q.safe && (seq_q.nxt < SLOT_END)) begin
                    seq_d.addr = slot_base(seq_q.nxt[IDX_W-1:0]);
                    seq_d.nxt  = seq_q.nxt + 1'b1;
                end else begin
                    seq_d.req  = 1'b0;
                    seq_d.safe = 1'b0;
                end
            end
        end else if (job_valid_i) begin
            seq_d.req = 1'b1;
            case (job_kind_i)
                JOB_PROGRAM: begin
                    seq_d.op   = FL_PROGRAM;
                    seq_d.addr = job_addr_i;
                end
                JOB_SAFE: begin
                    seq_d.op   = FL_ERASE;
                    seq_d.addr = slot_base(IDX_W'(1));
                    seq_d.safe = 1'b1;
                    seq_d.nxt  = (IDX_W+1)'(2);
                end
                default: begin
                    seq_d.op   = FL_ERASE;
                    seq_d.addr = job_addr_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign seq_busy_o   = seq_q.req;
    assign flash_req_o  = seq_q.req;
    assign flash_op_o   = seq_q.op;
    assign flash_addr_o = seq_q.addr;

    // R5: nothing sent to the flash may land in the factory slot
    assert_no_slot0_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req_o |-> (flash_addr_o[ADDR_W-1:SLOT_SHIFT] != '0));

    // R4: a request holds its operation and address until granted
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req_o && !flash_gnt_i) |=>
            (flash_req_o && $stable(flash_addr_o) && $stable(flash_op_o)));

    // R7: during safe erase a grant moves to the next slot up
    assert_safe_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req_o && flash_gnt_i && seq_q.safe && (seq_q.nxt < SLOT_END)) |=>
            (flash_req_o && (flash_addr_o[ADDR_W-1:SLOT_SHIFT] ==
                             $past(flash_addr_o[ADDR_W-1:SLOT_SHIFT]) + 1'b1)));
endmodule

// File: rtl/bis_cmd_ctrl.sv
module bis_cmd_ctrl
    import bis_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int SLOT_SHIFT = 23,
    parameter int SEL_W      = 3,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int ADDR_W    = SLOT_SHIFT + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sw_sync_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [SEL_W-1:0]  cmd_slot_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              seq_busy_i,
    output logic              job_valid_o,
    output job_e              job_kind_o,
    output logic [ADDR_W-1:0] job_addr_o,
    output logic              busy_o,
    output logic [IDX_W-1:0]  active_slot_o,
    output logic              prot_err_o,
    output logic              slot_err_o,
    output logic              cfg_start_o,
    output logic [ADDR_W-1:0] cfg_addr_o
);
    localparam logic [SEL_W:0] SLOT_LIMIT = (SEL_W+1)'(NUM_SLOTS);
    localparam logic [1:0]     BOOT_WAIT  = 2'd2;

    typedef struct packed {
        logic [1:0]        init_cnt;
        logic              ready;
        logic [SEL_W-1:0]  sel;
        logic [IDX_W-1:0]  active;
        logic              cfg_start;
        logic [ADDR_W-1:0] cfg_addr;
        logic              prot_err;
        logic              slot_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    function automatic logic in_range(input logic [SEL_W-1:0] s);
        return ({1'b0, s} < SLOT_LIMIT);
    endfunction

    function automatic logic [ADDR_W-1:0] slot_base(input logic [IDX_W-1:0] s);
        return {s, {SLOT_SHIFT{1'b0}}};
    endfunction

    assign busy_o = !ctl_q.ready || seq_busy_i || ctl_q.cfg_start;
    assign accept = cmd_valid_i && !busy_o;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.cfg_start = 1'b0;
        job_valid_o     = 1'b0;
        job_kind_o      = JOB_ERASE;
        job_addr_o      = '0;
        if (!ctl_q.ready) begin
            if (ctl_q.init_cnt == BOOT_WAIT) begin
                ctl_d.ready     = 1'b1;
                ctl_d.active    = sw_sync_i;
                ctl_d.cfg_start = 1'b1;
                ctl_d.cfg_addr  = slot_base(sw_sync_i);
            end else begin
                ctl_d.init_cnt = ctl_q.init_cnt + 2'd1;
            end
        end else if (accept) begin
            case (cmd_op_i)
                OP_SELECT: begin
                    ctl_d.sel = cmd_slot_i;
                    if (!in_range(cmd_slot_i)) ctl_d.slot_err = 1'b1;
                end
                OP_COMMIT: begin
                    if (in_range(ctl_q.sel)) begin
                        ctl_d.cfg_start = 1'b1;
                        ctl_d.active    = ctl_q.sel[IDX_W-1:0];
                        ctl_d.cfg_addr  = slot_base(ctl_q.sel[IDX_W-1:0]);
                    end else begin
                        ctl_d.slot_err = 1'b1;
                    end
                end
                OP_ERASE: begin
                    if (!in_range(cmd_slot_i)) begin
                        ctl_d.slot_err = 1'b1;
                    end else if (cmd_slot_i == '0) begin
                        ctl_d.prot_err = 1'b1;
                    end else begin
                        job_valid_o = 1'b1;
                        job_kind_o  = JOB_ERASE;
                        job_addr_o  = slot_base(cmd_slot_i[IDX_W-1:0]);
                    end
                end
                OP_PROGRAM: begin
                    if (cmd_addr_i[ADDR_W-1:SLOT_SHIFT] == '0) begin
                        ctl_d.prot_err = 1'b1;
                    end else begin
                        job_valid_o = 1'b1;
                        job_kind_o  = JOB_PROGRAM;
                        job_addr_o  = cmd_addr_i;
                    end
                end
                OP_SAFE_ERASE: begin
                    job_valid_o = 1'b1;
                    job_kind_o  = JOB_SAFE;
                end
                OP_CLEAR: begin
                    if (cmd_addr_i[0]) ctl_d.prot_err = 1'b0;
                    if (cmd_addr_i[1]) ctl_d.slot_err = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign active_slot_o = ctl_q.active;
    assign prot_err_o    = ctl_q.prot_err;
    assign slot_err_o    = ctl_q.slot_err;
    assign cfg_start_o   = ctl_q.cfg_start;
    assign cfg_addr_o    = ctl_q.cfg_addr;

    // R2: a configuration start never lasts more than one cycle
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start_o |=> !cfg_start_o);

    // R3: committing an out-of-range slot gives an error and no pulse
    assert_bad_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op_i == OP_COMMIT && !in_range(ctl_q.sel)) |=>
            (!cfg_start_o && slot_err_o));

    // R8: flags stay set unless a clear command addresses them
    assert_sticky_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_err_o && !(accept && cmd_op_i == OP_CLEAR)) |=> slot_err_o);
    assert_sticky_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err_o && !(accept && cmd_op_i == OP_CLEAR)) |=> prot_err_o);

    // R9: new flash work only starts when the sequencer is idle
    assert_job_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid_o |-> !seq_busy_i);
endmodule

// File: rtl/boot_image_selector.sv
module boot_image_selector
    import bis_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int SLOT_SHIFT = 23,
    parameter int SEL_W      = 3,
    localparam int IDX_W     = $clog2(NUM_SLOTS),
    localparam int ADDR_W    = SLOT_SHIFT + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sw_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [SEL_W-1:0]  cmd_slot_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  active_slot_o,
    output logic              prot_err_o,
    output logic              slot_err_o,
    output logic              cfg_start_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic              flash_req_o,
    output logic              flash_op_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    input  logic              flash_gnt_i
);
    logic [IDX_W-1:0]  sw_sync;
    logic              job_valid;
    job_e              job_kind;
    logic [ADDR_W-1:0] job_addr;
    logic              seq_busy;

    bis_sync #(.W(IDX_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sw_i),
        .sync_o  (sw_sync)
    );

    bis_cmd_ctrl #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_SHIFT (SLOT_SHIFT),
        .SEL_W      (SEL_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_sync_i     (sw_sync),
        .cmd_valid_i   (cmd_valid_i),
        .cmd_op_i      (cmd_op_i),
        .cmd_slot_i    (cmd_slot_i),
        .cmd_addr_i    (cmd_addr_i),
        .seq_busy_i    (seq_busy),
        .job_valid_o   (job_valid),
        .job_kind_o    (job_kind),
        .job_addr_o    (job_addr),
        .busy_o        (busy_o),
        .active_slot_o (active_slot_o),
        .prot_err_o    (prot_err_o),
        .slot_err_o    (slot_err_o),
        .cfg_start_o   (cfg_start_o),
        .cfg_addr_o    (cfg_addr_o)
    );

    bis_flash_seq #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_SHIFT (SLOT_SHIFT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .job_valid_i  (job_valid),
        .job_kind_i   (job_kind),
        .job_addr_i   (job_addr),
        .seq_busy_o   (seq_busy),
        .flash_req_o  (flash_req_o),
        .flash_op_o   (flash_op_o),
        .flash_addr_o (flash_addr_o),
        .flash_gnt_i  (flash_gnt_i)
    );
endmodule

// File: tb/boot_image_selector_test.sv
module boot_image_selector_test;
    localparam int AW = 25;
    localparam int GNT_LAT = 3;
    localparam logic [2:0] C_SELECT = 3'd0, C_COMMIT = 3'd1, C_ERASE = 3'd2,
                           C_PROGRAM = 3'd3, C_SAFE = 3'd4, C_CLEAR = 3'd5;

    typedef struct packed {
        logic          op;
        logic [AW-1:0] addr;
    } fl_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sw = 2'b10;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_slot = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          busy, prot_err, slot_err, cfg_start, flash_req, flash_op;
    logic [1:0]    active_slot;
    logic [AW-1:0] cfg_addr, flash_addr;
    logic          flash_gnt = 1'b0;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int gcnt = 0;
    bit done = 0;
    fl_item_t       fl_q[$];
    logic [AW-1:0]  cfg_q[$];

    always #4 clk = ~clk;

    boot_image_selector uut (
        .clk (clk), .rst_n (rst_n), .sw_i (sw),
        .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op),
        .cmd_slot_i (cmd_slot), .cmd_addr_i (cmd_addr),
        .busy_o (busy), .active_slot_o (active_slot),
        .prot_err_o (prot_err), .slot_err_o (slot_err),
        .cfg_start_o (cfg_start), .cfg_addr_o (cfg_addr),
        .flash_req_o (flash_req), .flash_op_o (flash_op),
        .flash_addr_o (flash_addr), .flash_gnt_i (flash_gnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [2:0] slot,
                            input logic [AW-1:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_slot  = slot;
        cmd_addr  = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    // Flash model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_start) begin
                pulses++;
                if (cfg_q.size() == 0)
                    chk(0, "R2/R3", "unexpected cfg pulse", 32'(cfg_addr), 32'hFFFFFFFF);
                else begin
                    logic [AW-1:0] e;
                    e = cfg_q.pop_front();
                    chk(cfg_addr == e, "R1/R2", "cfg address", 32'(cfg_addr), 32'(e));
                end
            end
            if (flash_gnt) begin
                flash_gnt = 1'b0;
                gcnt = 0;
            end else if (flash_req) begin
                gcnt++;
                if (gcnt == GNT_LAT) begin
                    flash_gnt = 1'b1;
                    if (fl_q.size() == 0)
                        chk(0, "R5", "unexpected flash request", 32'(flash_addr), 32'hFFFFFFFF);
                    else begin
                        fl_item_t e;
                        e = fl_q.pop_front();
                        chk({flash_op, flash_addr} == e, "R4/R6/R7", "flash op+addr",
                            32'({flash_op, flash_addr}), 32'(e));
                    end
                end
            end
        end
    end

    initial begin
        int pc;
        cfg_q.push_back(25'h1000000);          // R1: switches select slot 2
        repeat (3) @(negedge clk);
        chk(!cfg_start && !flash_req && busy && !prot_err && !slot_err,
            "R1", "reset state", {27'd0, cfg_start, flash_req, busy, prot_err, slot_err},
            32'h4);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);             // R1: pulse due after third edge
        chk(cfg_start == 1'b1, "R1", "boot pulse timing", 32'(cfg_start), 1);
        chk(active_slot == 2'd2, "R1", "boot slot", 32'(active_slot), 2);
        wait_idle();

        // R2: select and commit
        send_cmd(C_SELECT, 3'd1, '0);
        cfg_q.push_back(25'h0800000);
        send_cmd(C_COMMIT, 3'd0, '0);
        chk(cfg_start == 1'b1, "R2", "commit pulse", 32'(cfg_start), 1);
        wait_idle();
        chk(active_slot == 2'd1, "R2", "active slot 1", 32'(active_slot), 1);
        send_cmd(C_SELECT, 3'd3, '0);
        cfg_q.push_back(25'h1800000);
        send_cmd(C_COMMIT, 3'd0, '0);
        wait_idle();
        chk(active_slot == 2'd3, "R2", "active slot 3", 32'(active_slot), 3);

        // R3: out-of-range slot
        send_cmd(C_SELECT, 3'd5, '0);
        chk(slot_err == 1'b1, "R3", "slot error on select", 32'(slot_err), 1);
        pc = pulses;
        send_cmd(C_COMMIT, 3'd0, '0);
        repeat (2) @(negedge clk);
        chk(pulses == pc, "R3", "no pulse for bad slot", pc, pulses);
        chk(active_slot == 2'd3, "R3", "active slot kept", 32'(active_slot), 3);

        // R8: clear slot error only
        send_cmd(C_CLEAR, 3'd0, 25'h2);
        chk(!slot_err && !prot_err, "R8", "slot error cleared", 32'({slot_err, prot_err}), 0);
        send_cmd(C_ERASE, 3'd6, '0);
        chk(slot_err && !flash_req, "R3", "erase bad slot", 32'({slot_err, flash_req}), 2);

        // R4: erase slot 2, held until grant
        wait_idle();
        fl_q.push_back({1'b0, 25'h1000000});
        send_cmd(C_ERASE, 3'd2, '0);
        chk(flash_req && flash_addr == 25'h1000000, "R4", "erase request", 32'(flash_addr), 32'h1000000);
        @(negedge clk);
        chk(flash_req && flash_addr == 25'h1000000 && flash_op == 1'b0, "R4", "request held",
            32'(flash_addr), 32'h1000000);
        wait_idle();

        // R5: protected slot 0
        send_cmd(C_ERASE, 3'd0, '0);
        chk(prot_err && !flash_req, "R5", "erase slot 0 refused", 32'({prot_err, flash_req}), 2);
        send_cmd(C_CLEAR, 3'd0, 25'h1);
        chk(!prot_err && slot_err, "R8", "prot cleared, slot kept", 32'({prot_err, slot_err}), 1);
        send_cmd(C_PROGRAM, 3'd0, 25'h07FFFF0);
        chk(prot_err && !flash_req, "R5", "program slot 0 refused", 32'({prot_err, flash_req}), 2);

        // R6: program above slot 0
        wait_idle();
        fl_q.push_back({1'b1, 25'h1234560});
        send_cmd(C_PROGRAM, 3'd0, 25'h1234560);
        chk(flash_req && flash_op, "R6", "program request", 32'({flash_req, flash_op}), 3);
        wait_idle();

        // R7: safe erase
        fl_q.push_back({1'b0, 25'h0800000});
        fl_q.push_back({1'b0, 25'h1000000});
        fl_q.push_back({1'b0, 25'h1800000});
        send_cmd(C_SAFE, 3'd0, '0);
        wait_idle();
        chk(fl_q.size() == 0, "R7", "safe erase done", fl_q.size(), 0);

        // R9: command while busy is ignored
        send_cmd(C_SELECT, 3'd1, '0);
        fl_q.push_back({1'b0, 25'h1000000});
        send_cmd(C_ERASE, 3'd2, '0);
        send_cmd(C_SELECT, 3'd0, '0);          // arrives while flash is busy
        wait_idle();
        cfg_q.push_back(25'h0800000);
        send_cmd(C_COMMIT, 3'd0, '0);
        wait_idle();
        chk(active_slot == 2'd1, "R9", "busy select ignored", 32'(active_slot), 1);

        repeat (4) @(negedge clk);
        chk(cfg_q.size() == 0 && fl_q.size() == 0, "R2/R4", "scoreboard drained",
            32'(cfg_q.size() + fl_q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule